// File: doc/BRIEF.md
# Dual-CPU Doorbell Mailbox

This block lets a host processor and a service processor signal each other through small register-mapped channels. Each channel holds two 32-bit message words and four shared flags: X1 and X2, which belong to the host, and Y1 and Y2, which belong to the service side. Both processors see the flags through two control words. The flags sit at different bit positions in each word. A side sets and clears its own flags directly. It clears the other side's flags by writing 1. It can also choose which of the other side's flags raise its own interrupt.

There are four independent channels: a legacy channel at offset 0x000 and three per-core channels at 0x400, 0x410 and 0x420. There are two register ports. Each port carries a requester bit that says whether the access comes from the host or from the service processor. The service control word is private to the service processor. Each channel has its own registered host and service interrupt lines. A per-side OR merges them into one host line and one service line.

A typical exchange runs like this. The host puts a command pointer in its message word and sets X1. The service side takes the interrupt and sets Y2 to acknowledge. It clears X1 and later sets Y1 once the reply word is ready.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every message word, flag, enable, interrupt line and read data output is zero.
- R2: Byte address 0x000 selects the legacy channel. Addresses 0x400 + 0x10*k select per-core channel k (k = 0..2). Within a channel, offsets 0x0, 0x4, 0x8 and 0xC are the host message, host control, service message and service control words. A misaligned address, or one outside these blocks, writes nothing and reads zero.
- R3: Both message words can be read and written by either requester, with no side effect on flags or interrupts.
- R4: Host control word layout: bit0 = X1 (written value is stored), bit3 = X2 (written value is stored), bit1 = Y2 (write 1 clears), bit2 = Y1 (write 1 clears), bit4 = Y1 interrupt enable, bit5 = Y2 interrupt enable. Bits 31:6 read as zero. Either requester may write this word.
- R5: Service control word layout: bit0 = Y1 (written value is stored), bit3 = Y2 (written value is stored), bit1 = X2 (write 1 clears), bit2 = X1 (write 1 clears), bit4 = X1 interrupt enable, bit5 = X2 interrupt enable. Bits 31:6 read as zero.
- R6: Writing 0 to a write-1-to-clear bit leaves that flag unchanged.
- R7: A host-requester access (source bit 0) to the service control word changes nothing and reads zero.
- R8: A channel's host interrupt equals (Y1 and its enable) or (Y2 and its enable), and its service interrupt equals (X1 and its enable) or (X2 and its enable). Both are evaluated on the state one cycle earlier, so they change one cycle after the flag or enable changes.
- R9: host_irq is the OR of all per-channel host interrupts, and svc_irq is the OR of all per-channel service interrupts.
- R10: If both ports write in the same cycle, a set of a flag wins over a clear of that flag. For message words and enables, the value from port 1 wins.
- R11: Read data appears on the port one cycle after the read request and shows the state before any write made in that same cycle. In a cycle that follows no read, read data is zero.
- R12: Channels are independent: an access to one channel never changes another channel's words, flags or interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_req | input | 1 | Port 0 access request |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_src | input | 1 | Port 0 requester: 0 host, 1 service |
| p0_addr | input | 12 | Port 0 byte address |
| p0_wdata | input | 32 | Port 0 write data |
| p0_rdata | output | 32 | Port 0 read data, one cycle after request |
| p1_req | input | 1 | Port 1 access request |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_src | input | 1 | Port 1 requester: 0 host, 1 service |
| p1_addr | input | 12 | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 write data |
| p1_rdata | output | 32 | Port 1 read data, one cycle after request |
| host_irq_ch | output | 4 | Per-channel host interrupt (bit 0 legacy) |
| svc_irq_ch | output | 4 | Per-channel service interrupt (bit 0 legacy) |
| host_irq | output | 1 | OR of all host interrupts |
| svc_irq | output | 1 | OR of all service interrupts |

## Verification
The bench targets the following corner cases, each with the failure it would expose.

- Same-cycle collisions between the two ports. A design that lets a clear win over a set would lose a doorbell that was raised at the moment the other side was clearing it.
- Writes with a zero in a write-1-to-clear bit. A design that treats these bits as plain storage would drop the other side's pending flags on every enable update.
- Host-requester accesses to the service control word. A leaky permission check would let the host change the service enables or read them.
- Unmapped and misaligned addresses, and traffic in one channel. These would reveal address aliasing between channels.
- The full command, acknowledge and reply exchange. This checks that each interrupt rises and falls exactly one cycle after its flag.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        REG_HMSG = 2'd0,
        REG_HCTL = 2'd1,
        REG_SMSG = 2'd2,
        REG_SCTL = 2'd3
    } reg_idx_e;

    // One port's access as seen by one channel
    typedef struct packed {
        logic              sel;
        logic              we;
        logic              svc;
        reg_idx_e          idx;
        logic [DATA_W-1:0] wdata;
    } chan_acc_t;

    typedef struct packed {
        logic x1;
        logic x2;
        logic y1;
        logic y2;
        logic en_x1;
        logic en_x2;
        logic en_y1;
        logic en_y2;
    } flag_set_t;

    typedef struct packed {
        logic [DATA_W-1:0] hmsg;
        logic [DATA_W-1:0] smsg;
        flag_set_t         f;
        logic              hirq;
        logic              sirq;
    } chan_state_t;

    // Host-side control view
    function automatic logic [DATA_W-1:0] host_ctl_word(flag_set_t f);
        logic [DATA_W-1:0] v;
        v    = '0;
        v[0] = f.x1;
        v[1] = f.y2;
        v[2] = f.y1;
        v[3] = f.x2;
        v[4] = f.en_y1;
        v[5] = f.en_y2;
        return v;
    endfunction

    // Service-side control view
    function automatic logic [DATA_W-1:0] svc_ctl_word(flag_set_t f);
        logic [DATA_W-1:0] v;
        v    = '0;
        v[0] = f.y1;
        v[1] = f.x2;
        v[2] = f.x1;
        v[3] = f.y2;
        v[4] = f.en_x1;
        v[5] = f.en_x2;
        return v;
    endfunction

endpackage

// File: rtl/ipc_addr_dec.sv
module ipc_addr_dec
    import ipc_mbox_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                NUM_CORE  = 3,
    parameter logic [ADDR_W-1:0] CORE_BASE = 12'h400,
    localparam int               NCH       = NUM_CORE + 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    hit,
    output reg_idx_e          idx
);

    localparam int              BLK_W    = ADDR_W - 4;
    localparam logic [BLK_W-1:0] CORE_BLK = CORE_BASE[ADDR_W-1:4];

    logic aligned;

    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        idx     = reg_idx_e'(addr[3:2]);
        hit     = '0;
        if (aligned && addr[ADDR_W-1:4] == '0) begin
            hit[0] = 1'b1;
        end
        for (int c = 0; c < NUM_CORE; c++) begin
            if (aligned && addr[ADDR_W-1:4] == CORE_BLK + BLK_W'(c)) begin
                hit[c+1] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ipc_channel.sv
module ipc_channel
    import ipc_mbox_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  chan_acc_t [NPORT-1:0]       acc,
    output logic [DATA_W-1:0]           host_msg,
    output logic [DATA_W-1:0]           svc_msg,
    output flag_set_t                   flags,
    output logic                        host_irq,
    output logic                        svc_irq
);

    chan_state_t st_d, st_q;

    // Per-flag set and clear requests gathered over all ports
    logic set_x1, set_x2, set_y1, set_y2;
    logic clr_x1, clr_x2, clr_y1, clr_y2;

    always_comb begin
        st_d   = st_q;
        set_x1 = 1'b0; set_x2 = 1'b0; set_y1 = 1'b0; set_y2 = 1'b0;
        clr_x1 = 1'b0; clr_x2 = 1'b0; clr_y1 = 1'b0; clr_y2 = 1'b0;

        for (int p = 0; p < NPORT; p++) begin
            if (acc[p].sel && acc[p].we) begin
                case (acc[p].idx)
                    REG_HMSG: st_d.hmsg = acc[p].wdata;
                    REG_SMSG: st_d.smsg = acc[p].wdata;
                    REG_HCTL: begin
                        if (acc[p].wdata[0]) set_x1 = 1'b1; else clr_x1 = 1'b1;
                        if (acc[p].wdata[3]) set_x2 = 1'b1; else clr_x2 = 1'b1;
                        if (acc[p].wdata[1]) clr_y2 = 1'b1;
                        if (acc[p].wdata[2]) clr_y1 = 1'b1;
                        st_d.f.en_y1 = acc[p].wdata[4];
                        st_d.f.en_y2 = acc[p].wdata[5];
                    end
                    REG_SCTL: begin
                        if (acc[p].svc) begin
                            if (acc[p].wdata[0]) set_y1 = 1'b1; else clr_y1 = 1'b1;
                            if (acc[p].wdata[3]) set_y2 = 1'b1; else clr_y2 = 1'b1;
                            if (acc[p].wdata[1]) clr_x2 = 1'b1;
                            if (acc[p].wdata[2]) clr_x1 = 1'b1;
                            st_d.f.en_x1 = acc[p].wdata[4];
                            st_d.f.en_x2 = acc[p].wdata[5];
                        end
                    end
                    default: ;
                endcase
            end
        end

        // A set beats a clear arriving in the same cycle
        st_d.f.x1 = set_x1 | (st_q.f.x1 & ~clr_x1);
        st_d.f.x2 = set_x2 | (st_q.f.x2 & ~clr_x2);
        st_d.f.y1 = set_y1 | (st_q.f.y1 & ~clr_y1);
        st_d.f.y2 = set_y2 | (st_q.f.y2 & ~clr_y2);

        // Interrupts follow the registered flags one cycle later
        st_d.hirq = (st_q.f.y1 & st_q.f.en_y1) | (st_q.f.y2 & st_q.f.en_y2);
        st_d.sirq = (st_q.f.x1 & st_q.f.en_x1) | (st_q.f.x2 & st_q.f.en_x2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_msg = st_q.hmsg;
    assign svc_msg  = st_q.smsg;
    assign flags    = st_q.f;
    assign host_irq = st_q.hirq;
    assign svc_irq  = st_q.sirq;

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                NUM_CORE  = 3,
    parameter logic [ADDR_W-1:0] CORE_BASE = 12'h400,
    localparam int               NCH       = NUM_CORE + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_req,
    input  logic              p0_we,
    input  logic              p0_src,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [31:0]       p0_wdata,
    output logic [31:0]       p0_rdata,
    input  logic              p1_req,
    input  logic              p1_we,
    input  logic              p1_src,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [31:0]       p1_wdata,
    output logic [31:0]       p1_rdata,
    output logic [NCH-1:0]    host_irq_ch,
    output logic [NCH-1:0]    svc_irq_ch,
    output logic              host_irq,
    output logic              svc_irq
);

    localparam int NPORT = 2;

    logic [NPORT-1:0]                 pt_req, pt_we, pt_svc;
    logic [NPORT-1:0][ADDR_W-1:0]     pt_addr;
    logic [NPORT-1:0][DATA_W-1:0]     pt_wdata;

    assign pt_req   = {p1_req,   p0_req};
    assign pt_we    = {p1_we,    p0_we};
    assign pt_svc   = {p1_src,   p0_src};
    assign pt_addr  = {p1_addr,  p0_addr};
    assign pt_wdata = {p1_wdata, p0_wdata};

    logic [NPORT-1:0][NCH-1:0] dec_hit;
    reg_idx_e                  dec_idx [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        ipc_addr_dec #(
            .ADDR_W    (ADDR_W),
            .NUM_CORE  (NUM_CORE),
            .CORE_BASE (CORE_BASE)
        ) u_dec (
            .addr (pt_addr[p]),
            .hit  (dec_hit[p]),
            .idx  (dec_idx[p])
        );
    end

    chan_acc_t [NCH-1:0][NPORT-1:0] ch_acc;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            for (int p = 0; p < NPORT; p++) begin
                ch_acc[c][p].sel   = pt_req[p] & dec_hit[p][c];
                ch_acc[c][p].we    = pt_we[p];
                ch_acc[c][p].svc   = pt_svc[p];
                ch_acc[c][p].idx   = dec_idx[p];
                ch_acc[c][p].wdata = pt_wdata[p];
            end
        end
    end

    logic [NCH-1:0][DATA_W-1:0] ch_hmsg, ch_smsg;
    flag_set_t [NCH-1:0]        ch_flags;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ipc_channel #(
            .NPORT (NPORT)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc      (ch_acc[c]),
            .host_msg (ch_hmsg[c]),
            .svc_msg  (ch_smsg[c]),
            .flags    (ch_flags[c]),
            .host_irq (host_irq_ch[c]),
            .svc_irq  (svc_irq_ch[c])
        );
    end

    // Registered read return
    logic [NPORT-1:0][DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (pt_req[p] && !pt_we[p]) begin
                for (int c = 0; c < NCH; c++) begin
                    if (dec_hit[p][c]) begin
                        case (dec_idx[p])
                            REG_HMSG: rd_d[p] = ch_hmsg[c];
                            REG_HCTL: rd_d[p] = host_ctl_word(ch_flags[c]);
                            REG_SMSG: rd_d[p] = ch_smsg[c];
                            REG_SCTL: rd_d[p] = pt_svc[p] ? svc_ctl_word(ch_flags[c]) : '0;
                            default:  rd_d[p] = '0;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign p0_rdata = rd_q[0];
    assign p1_rdata = rd_q[1];
    assign host_irq = |host_irq_ch;
    assign svc_irq  = |svc_irq_ch;

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
    import ipc_mbox_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCH    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              p0_req,
    input logic              p0_we,
    input logic              p0_src,
    input logic [ADDR_W-1:0] p0_addr,
    input logic [31:0]       p0_rdata,
    input logic              p1_req,
    input logic              p1_we,
    input logic              p1_src,
    input logic [ADDR_W-1:0] p1_addr,
    input logic [31:0]       p1_rdata,
    input logic [NCH-1:0]    host_irq_ch,
    input logic [NCH-1:0]    svc_irq_ch,
    input flag_set_t [NCH-1:0] ch_flags
);

    // R7
    p0_host_sctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req && !p0_we && !p0_src && p0_addr[3:2] == 2'b11) |=> (p0_rdata == '0));

    // R7
    p1_host_sctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_req && !p1_we && !p1_src && p1_addr[3:2] == 2'b11) |=> (p1_rdata == '0));

    // R4
    p0_ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req && !p0_we && p0_addr[2]) |=> (p0_rdata[31:6] == '0));

    // R5
    p1_ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_req && !p1_we && p1_addr[2]) |=> (p1_rdata[31:6] == '0));

    // R11
    p0_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(p0_req && !p0_we) |=> (p0_rdata == '0));

    // R11
    p1_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(p1_req && !p1_we) |=> (p1_rdata == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_irq
        // R8
        host_irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            host_irq_ch[c] == $past((ch_flags[c].y1 & ch_flags[c].en_y1) |
                                    (ch_flags[c].y2 & ch_flags[c].en_y2)));
        // R8
        svc_irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            svc_irq_ch[c] == $past((ch_flags[c].x1 & ch_flags[c].en_x1) |
                                   (ch_flags[c].x2 & ch_flags[c].en_x2)));
    end

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .ADDR_W (ADDR_W),
    .NCH    (NCH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .p0_req      (p0_req),
    .p0_we       (p0_we),
    .p0_src      (p0_src),
    .p0_addr     (p0_addr),
    .p0_rdata    (p0_rdata),
    .p1_req      (p1_req),
    .p1_we       (p1_we),
    .p1_src      (p1_src),
    .p1_addr     (p1_addr),
    .p1_rdata    (p1_rdata),
    .host_irq_ch (host_irq_ch),
    .svc_irq_ch  (svc_irq_ch),
    .ch_flags    (ch_flags)
);

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_req [2];
    logic        b_we  [2];
    logic        b_src [2];
    logic [11:0] b_addr[2];
    logic [31:0] b_wd  [2];
    logic [31:0] p0_rdata, p1_rdata;
    logic [NCH-1:0] host_irq_ch, svc_irq_ch;
    logic        host_irq, svc_irq;

    always #4 clk = ~clk;   // 125 MHz

    ipc_mailbox i_ipc_mailbox (
        .clk         (clk),
        .rst_n       (rst_n),
        .p0_req      (b_req[0]),
        .p0_we       (b_we[0]),
        .p0_src      (b_src[0]),
        .p0_addr     (b_addr[0]),
        .p0_wdata    (b_wd[0]),
        .p0_rdata    (p0_rdata),
        .p1_req      (b_req[1]),
        .p1_we       (b_we[1]),
        .p1_src      (b_src[1]),
        .p1_addr     (b_addr[1]),
        .p1_wdata    (b_wd[1]),
        .p1_rdata    (p1_rdata),
        .host_irq_ch (host_irq_ch),
        .svc_irq_ch  (svc_irq_ch),
        .host_irq    (host_irq),
        .svc_irq     (svc_irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_hmsg[NCH], m_smsg[NCH];
    bit m_x1[NCH], m_x2[NCH], m_y1[NCH], m_y2[NCH];
    bit m_ex1[NCH], m_ex2[NCH], m_ey1[NCH], m_ey2[NCH];
    logic [31:0]    exp_rd[2];
    logic [NCH-1:0] exp_h, exp_s;
    bit model_ok = 0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string phase = "R1";

    function automatic int chan_of(logic [11:0] a);
        if (a[1:0] != 2'b00) return -1;
        if (a < 12'h010) return 0;
        if (a >= 12'h400 && a < 12'h430) return 1 + int'((a - 12'h400) >> 4);
        return -1;
    endfunction

    function automatic logic [31:0] read_m(logic [11:0] a, bit s);
        int c;
        c = chan_of(a);
        if (c < 0) return 32'h0;
        case (a[3:2])
            2'd0: return m_hmsg[c];
            2'd1: return {26'b0, m_ey2[c], m_ey1[c], m_x2[c], m_y1[c], m_y2[c], m_x1[c]};
            2'd2: return m_smsg[c];
            default: return s ? {26'b0, m_ex2[c], m_ex1[c], m_y2[c], m_x1[c], m_x2[c], m_y1[c]} : 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_hmsg[c] = 0; m_smsg[c] = 0;
                m_x1[c] = 0; m_x2[c] = 0; m_y1[c] = 0; m_y2[c] = 0;
                m_ex1[c] = 0; m_ex2[c] = 0; m_ey1[c] = 0; m_ey2[c] = 0;
            end
            exp_rd[0] = 0; exp_rd[1] = 0; exp_h = 0; exp_s = 0;
        end else begin
            bit sx1[NCH], sx2[NCH], sy1[NCH], sy2[NCH];
            bit cx1[NCH], cx2[NCH], cy1[NCH], cy2[NCH];
            for (int p = 0; p < 2; p++)
                exp_rd[p] = (b_req[p] && !b_we[p]) ? read_m(b_addr[p], b_src[p]) : 32'h0;
            for (int c = 0; c < NCH; c++) begin
                exp_h[c] = (m_y1[c] && m_ey1[c]) || (m_y2[c] && m_ey2[c]);
                exp_s[c] = (m_x1[c] && m_ex1[c]) || (m_x2[c] && m_ex2[c]);
                sx1[c] = 0; sx2[c] = 0; sy1[c] = 0; sy2[c] = 0;
                cx1[c] = 0; cx2[c] = 0; cy1[c] = 0; cy2[c] = 0;
            end
            for (int p = 0; p < 2; p++) begin
                int c;
                logic [31:0] d;
                c = chan_of(b_addr[p]);
                d = b_wd[p];
                if (b_req[p] && b_we[p] && c >= 0) begin
                    case (b_addr[p][3:2])
                        2'd0: m_hmsg[c] = d;
                        2'd2: m_smsg[c] = d;
                        2'd1: begin
                            if (d[0]) sx1[c] = 1; else cx1[c] = 1;
                            if (d[3]) sx2[c] = 1; else cx2[c] = 1;
                            if (d[1]) cy2[c] = 1;
                            if (d[2]) cy1[c] = 1;
                            m_ey1[c] = d[4]; m_ey2[c] = d[5];
                        end
                        default: if (b_src[p]) begin
                            if (d[0]) sy1[c] = 1; else cy1[c] = 1;
                            if (d[3]) sy2[c] = 1; else cy2[c] = 1;
                            if (d[1]) cx2[c] = 1;
                            if (d[2]) cx1[c] = 1;
                            m_ex1[c] = d[4]; m_ex2[c] = d[5];
                        end
                    endcase
                end
            end
            for (int c = 0; c < NCH; c++) begin
                m_x1[c] = sx1[c] || (m_x1[c] && !cx1[c]);
                m_x2[c] = sx2[c] || (m_x2[c] && !cx2[c]);
                m_y1[c] = sy1[c] || (m_y1[c] && !cy1[c]);
                m_y2[c] = sy2[c] || (m_y2[c] && !cy2[c]);
            end
        end
        model_ok = 1;
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_ok) begin
            chk("p0_rdata", p0_rdata, exp_rd[0]);
            chk("p1_rdata", p1_rdata, exp_rd[1]);
            chk("host_irq_ch", 32'(host_irq_ch), 32'(exp_h));
            chk("svc_irq_ch", 32'(svc_irq_ch), 32'(exp_s));
            // R9 combined lines
            chk("host_irq R9", 32'(host_irq), 32'(|exp_h));
            chk("svc_irq R9", 32'(svc_irq), 32'(|exp_s));
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=%0d exp<100000", cycles);
            report();
        end
    end

    // ---------------- stimulus ----------------
    task automatic go(input bit r0, bit w0, bit s0, logic [11:0] a0, logic [31:0] d0,
                      input bit r1, bit w1, bit s1, logic [11:0] a1, logic [31:0] d1);
        @(negedge clk);
        b_req[0] = r0; b_we[0] = w0; b_src[0] = s0; b_addr[0] = a0; b_wd[0] = d0;
        b_req[1] = r1; b_we[1] = w1; b_src[1] = s1; b_addr[1] = a1; b_wd[1] = d1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) go(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input bit s, input logic [11:0] a, input logic [31:0] d);
        go(1, 1, s, a, d, 0, 0, 0, 0, 0);
    endtask

    task automatic rd(input bit s, input logic [11:0] a);
        go(0, 0, 0, 0, 0, 1, 0, s, a, 0);
    endtask

    task automatic rd_all(input logic [11:0] base);
        for (int r = 0; r < 4; r++) begin
            rd(1, base + 12'(4 * r));
            rd(0, base + 12'(4 * r));
        end
    endtask

    initial begin
        for (int p = 0; p < 2; p++) begin
            b_req[p] = 0; b_we[p] = 0; b_src[p] = 0; b_addr[p] = 0; b_wd[p] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        phase = "R1";
        idle(2);
        rd_all(12'h000);
        rd_all(12'h420);

        phase = "R2";
        wr(0, 12'h000, 32'hA000_0000);
        wr(0, 12'h400, 32'hA100_0001);
        wr(1, 12'h410, 32'hA200_0002);
        wr(1, 12'h420, 32'hA300_0003);
        wr(0, 12'h430, 32'hDEAD_0004);
        wr(0, 12'h010, 32'hDEAD_0005);
        wr(0, 12'h401, 32'hDEAD_0006);
        wr(1, 12'h40F, 32'h0000_003F);
        for (int c = 0; c < 4; c++) rd(0, (c == 0) ? 12'h000 : 12'h400 + 12'(16 * (c - 1)));
        rd(0, 12'h430); rd(1, 12'h010); rd(0, 12'h401); rd(1, 12'h40C); rd(1, 12'h800);

        phase = "R3";
        go(1, 1, 0, 12'h408, 32'h1357_9BDF, 1, 1, 1, 12'h404, 32'h0);
        wr(1, 12'h400, 32'h2468_ACE0);
        rd_all(12'h400);

        phase = "R4";
        wr(0, 12'h414, 32'hFFFF_FF39);
        rd_all(12'h410);

        phase = "R5";
        wr(1, 12'h41C, 32'hFFFF_FF39);
        idle(2);
        rd_all(12'h410);

        phase = "R6";
        wr(0, 12'h414, 32'h0000_0039);
        rd(0, 12'h414);
        wr(0, 12'h414, 32'h0000_003D);
        rd(0, 12'h414);
        wr(1, 12'h41C, 32'h0000_0039);
        rd(1, 12'h41C);
        wr(1, 12'h41C, 32'h0000_003F);
        rd(1, 12'h41C);
        idle(2);

        phase = "R7";
        wr(1, 12'h42C, 32'h0000_0019);
        wr(0, 12'h42C, 32'h0000_0026);
        rd(0, 12'h42C);
        rd(1, 12'h42C);
        idle(2);

        phase = "R8";
        wr(0, 12'h004, 32'h0000_0030);
        wr(1, 12'h00C, 32'h0000_0001);
        idle(3);
        wr(0, 12'h004, 32'h0000_0020);
        idle(2);
        wr(1, 12'h00C, 32'h0000_0008);
        idle(2);
        wr(0, 12'h004, 32'h0000_0002);
        idle(2);

        phase = "R10";
        go(1, 1, 1, 12'h40C, 32'h0000_0004, 1, 1, 0, 12'h404, 32'h0000_0001);
        go(1, 1, 0, 12'h404, 32'h0000_0000, 1, 1, 1, 12'h404, 32'h0000_0009);
        go(1, 1, 0, 12'h428, 32'h1111_1111, 1, 1, 1, 12'h428, 32'h2222_2222);
        go(1, 1, 1, 12'h42C, 32'h0000_0010, 1, 1, 1, 12'h42C, 32'h0000_0020);
        rd_all(12'h400);
        rd_all(12'h420);

        phase = "R11";
        go(1, 1, 0, 12'h418, 32'hCAFE_F00D, 1, 0, 1, 12'h418, 0);
        rd(1, 12'h418);
        idle(2);

        phase = "R12";
        wr(0, 12'h424, 32'h0000_0039);
        wr(1, 12'h42C, 32'h0000_0039);
        idle(2);
        rd_all(12'h000);
        rd_all(12'h400);
        rd_all(12'h410);
        rd_all(12'h420);

        // Command / acknowledge / reply exchange on per-core channel 0
        phase = "R8";
        for (int c = 0; c < 4; c++) begin
            wr(0, 12'h004 + 12'(c == 0 ? 0 : 12'h400 + 16 * (c - 1)), 32'h0);
            wr(1, 12'h00C + 12'(c == 0 ? 0 : 12'h400 + 16 * (c - 1)), 32'h6);
        end
        idle(2);
        wr(1, 12'h40C, 32'h0000_0010);
        wr(0, 12'h400, 32'h8000_1000);
        wr(0, 12'h404, 32'h0000_0031);
        idle(2);
        rd(1, 12'h400);
        wr(1, 12'h40C, 32'h0000_001C);
        idle(2);
        rd(0, 12'h404);
        wr(0, 12'h404, 32'h0000_0032);
        idle(2);
        wr(1, 12'h408, 32'h8000_2000);
        wr(1, 12'h40C, 32'h0000_0011);
        idle(2);
        rd(0, 12'h408);
        wr(0, 12'h404, 32'h0000_0034);
        idle(3);

        phase = "R10";
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a[2];
            for (int p = 0; p < 2; p++) begin
                int k;
                k = int'($urandom_range(0, 4));
                a[p] = ((k == 0) ? 12'h000 : 12'h400 + 12'(16 * (k - 1))) + 12'(4 * $urandom_range(0, 3));
            end
            go($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
               a[0], ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 63)) : $urandom(),
               $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
               a[1], ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 63)) : $urandom());
        end
        idle(3);
        report();
    end

endmodule